// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns any of three reset requests into a single system reset and then walks a fixed, ordered sequence before the processor is allowed to run. The requests are an external reset pin (already synchronized to the CPU clock), a low-supply-voltage flag, and a one-cycle watchdog expiry pulse. A debounce stage guards the pin. The two internal sources pull the pin low so that the rest of the board also sees the reset.

The sequence has three phases. The first is an active phase whose length depends on which source started the reset. The second is an oscillator stabilization wait of 256 or 4096 clock cycles, selected by a static configuration bit, with the pin pulled low the whole time. The third is a two-cycle fetch of the reset vector from the last two addresses of memory. A new request at any point restarts the sequence at the active phase. A sticky cause register records which sources have triggered resets since it was last cleared.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst` and `pin_pull_low` are 1 and `cause` is 0. After release, the wait phase runs for the selected length, counting the cycle in which `por_n` rises. The two vector-fetch cycles follow, and then reset is released.
- R2: A pin low for fewer than 3 consecutive sampled cycles does not start a reset.
- R3: A pin low for 3 consecutive samples starts an external reset. Its active phase lasts until the debounced pin is high again, and lasts at least 4 cycles. `pin_pull_low` is 0 during this phase.
- R4: A rising edge of `lvd_flag` starts a reset. The active phase lasts as long as `lvd_flag` stays 1, and `pin_pull_low` is 1 during it.
- R5: A `wdg_pulse` starts a reset whose active phase lasts exactly 30 cycles with `pin_pull_low` at 1.
- R6: The wait phase lasts 256 cycles when `dly_long` is 0 and 4096 cycles when it is 1. `pin_pull_low` is 1 throughout.
- R7: The fetch phase lasts exactly 2 cycles with `fetch_strobe` at 1. `fetch_addr` is 16'hFFFE in the first cycle and 16'hFFFF in the second, and 0 whenever `fetch_strobe` is 0.
- R8: `sys_rst` is 1 in every phase and falls in the cycle after the second fetch cycle.
- R9: Any new request, in any phase, restarts the sequence at the active phase of the new source.
- R10: `cause` bit 0 marks the external pin, bit 1 the low-voltage flag and bit 2 the watchdog. A request sets only the bit of its highest-priority simultaneous source (watchdog over voltage over pin). The bits accumulate and are otherwise held.
- R11: `cause_clr` zeroes `cause`. If a request arrives in the same cycle, only that request's bit is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_sync_n | input | 1 | Synchronized external reset pin level, low requests reset |
| lvd_flag | input | 1 | Low-supply-voltage flag |
| wdg_pulse | input | 1 | Watchdog expiry, one cycle |
| dly_long | input | 1 | Static wait select: 0 gives 256 cycles, 1 gives 4096 |
| cause_clr | input | 1 | Software clear of the cause register |
| sys_rst | output | 1 | Internal system reset, active high |
| pin_pull_low | output | 1 | Enable for the open-drain pull-down on the reset pin |
| fetch_strobe | output | 1 | High during the two vector-fetch cycles |
| fetch_addr | output | 16 | Vector byte address during fetch |
| cause | output | 3 | Sticky reset cause flags |

## Verification
The hardest situations to reach are restarts that land inside the short windows: a request during one of the two fetch cycles, and a pin request competing with the block's own pull-down. The stimulus waits, sampling each cycle, until `fetch_strobe` is seen, and fires the watchdog on the next edge. It also holds the pin low across the sequence end so that the debounce stage has to re-qualify the pin after the pull-down is released. A behavioural model compares every output on every clock, so a restart that is off by one cycle is caught wherever it happens.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ACT  = 3'd1,
    PH_DLY  = 3'd2,
    PH_F0   = 3'd3,
    PH_F1   = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_LVD = 2'd1,
    SRC_WDG = 2'd2
  } src_t;

  // Wait-phase length for a given configuration bit.
  function automatic int unsigned rsq_dly_len(logic lng, int unsigned short_len,
                                               int unsigned long_len);
    return lng ? long_len : short_len;
  endfunction

  // Highest-priority source among simultaneous requests.
  function automatic src_t rsq_pick(logic wdg, logic lvd);
    if (wdg) return SRC_WDG;
    if (lvd) return SRC_LVD;
    return SRC_EXT;
  endfunction

  // Cause flag position for a source.
  function automatic logic [2:0] rsq_bit(src_t s);
    return 3'b001 << s;
  endfunction

endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
  parameter int LOW_SAMPLES = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  input  logic mask,
  output logic ext_req,
  output logic pin_low
);
  localparam int CW = $clog2(LOW_SAMPLES + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                           run_q <= '0;
    else if (mask || pin_n)               run_q <= '0;
    else if (run_q != CW'(LOW_SAMPLES))   run_q <= run_q + CW'(1);
  end

  assign ext_req = !mask && !pin_n && (run_q == CW'(LOW_SAMPLES - 1));
  assign pin_low = (run_q == CW'(LOW_SAMPLES));
endmodule

// File: rtl/rsq_cause_reg.sv
module rsq_cause_reg
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       clr,
  input  logic       set_en,
  input  src_t       set_src,
  output logic [2:0] cause
);
  logic [2:0] cause_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cause_q <= '0;
    else if (clr || set_en)
      cause_q <= (clr ? 3'b000 : cause_q) | (set_en ? rsq_bit(set_src) : 3'b000);
  end

  assign cause = cause_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsq_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DLY_SHORT   = 256,
  parameter int DLY_LONG    = 4096,
  parameter int EXT_MIN     = 4,
  parameter int WDG_LEN     = 30,
  parameter int FILT_N      = 3,
  parameter logic [AW-1:0] VEC_ADDR = {{(AW-1){1'b1}}, 1'b0}
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          pin_sync_n,
  input  logic          lvd_flag,
  input  logic          wdg_pulse,
  input  logic          dly_long,
  input  logic          cause_clr,
  output logic          sys_rst,
  output logic          pin_pull_low,
  output logic          fetch_strobe,
  output logic [AW-1:0] fetch_addr,
  output logic [2:0]    cause
);
  localparam int CNT_W = $clog2(DLY_LONG + 1);

  phase_t           phase_q, phase_d;
  src_t             src_q, src_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvd_q;

  // Named internal events.
  logic ext_req, pin_low_f, lvd_req, req_any, act_done, dly_done;
  src_t req_src;

  assign lvd_req = lvd_flag & ~lvd_q;
  assign req_any = ext_req | lvd_req | wdg_pulse;
  assign req_src = rsq_pick(wdg_pulse, lvd_req);

  assign pin_pull_low = (phase_q == PH_DLY) ||
                        ((phase_q == PH_ACT) && (src_q != SRC_EXT));

  rsq_pin_filter #(.LOW_SAMPLES(FILT_N)) u_filt (
    .clk     (clk),
    .por_n   (por_n),
    .pin_n   (pin_sync_n),
    .mask    (pin_pull_low),
    .ext_req (ext_req),
    .pin_low (pin_low_f)
  );

  always_comb begin
    case (src_q)
      SRC_EXT: act_done = (cnt_q >= CNT_W'(EXT_MIN - 1)) && !pin_low_f;
      SRC_LVD: act_done = !lvd_flag;
      default: act_done = (cnt_q == CNT_W'(WDG_LEN - 1));
    endcase
  end

  assign dly_done = (cnt_q == CNT_W'(rsq_dly_len(dly_long, DLY_SHORT, DLY_LONG) - 1));

  always_comb begin
    phase_d = phase_q;
    src_d   = src_q;
    cnt_d   = cnt_q;
    if (req_any) begin
      phase_d = PH_ACT;
      src_d   = req_src;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_ACT: if (act_done) begin
                  phase_d = PH_DLY;
                  cnt_d   = '0;
                end else cnt_d = cnt_q + CNT_W'(1);
        PH_DLY: if (dly_done) begin
                  phase_d = PH_F0;
                  cnt_d   = '0;
                end else cnt_d = cnt_q + CNT_W'(1);
        PH_F0:  phase_d = PH_F1;
        PH_F1:  phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q <= PH_DLY;
      src_q   <= SRC_EXT;
      cnt_q   <= '0;
      lvd_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      src_q   <= src_d;
      cnt_q   <= cnt_d;
      lvd_q   <= lvd_flag;
    end
  end

  rsq_cause_reg u_cause (
    .clk     (clk),
    .por_n   (por_n),
    .clr     (cause_clr),
    .set_en  (req_any),
    .set_src (req_src),
    .cause   (cause)
  );

  assign sys_rst      = (phase_q != PH_IDLE);
  assign fetch_strobe = (phase_q == PH_F0) || (phase_q == PH_F1);
  assign fetch_addr   = (phase_q == PH_F0) ? VEC_ADDR :
                        (phase_q == PH_F1) ? VEC_ADDR + AW'(1) : '0;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk
  import rsq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096,
  parameter logic [AW-1:0] VEC_ADDR = {{(AW-1){1'b1}}, 1'b0}
) (
  input logic          clk,
  input logic          por_n,
  input logic          wdg_pulse,
  input logic          dly_long,
  input logic          cause_clr,
  input logic          sys_rst,
  input logic          pin_pull_low,
  input logic          fetch_strobe,
  input logic [AW-1:0] fetch_addr,
  input logic [2:0]    cause,
  input phase_t        phase
);
  localparam int CW = $clog2(DLY_LONG + 1) + 1;

  logic [CW-1:0] dcnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               dcnt_q <= '0;
    else if (phase == PH_DLY) dcnt_q <= dcnt_q + CW'(1);
    else                      dcnt_q <= '0;
  end

  p_delay_len_r6: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_F0) |-> (dcnt_q == CW'(rsq_dly_len(dly_long, DLY_SHORT, DLY_LONG))));

  p_fetch_order_r7: assert property (@(posedge clk) disable iff (!por_n)
    (fetch_strobe && fetch_addr == VEC_ADDR && !wdg_pulse) |=>
      (fetch_strobe && fetch_addr == VEC_ADDR + AW'(1)));

  p_fetch_addr_r7: assert property (@(posedge clk) disable iff (!por_n)
    !fetch_strobe |-> (fetch_addr == '0));

  p_release_r8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> ($past(fetch_strobe) && $past(fetch_addr) == VEC_ADDR + AW'(1)));

  p_pull_in_rst_r8: assert property (@(posedge clk) disable iff (!por_n)
    (pin_pull_low || fetch_strobe) |-> sys_rst);

  p_restart_r9: assert property (@(posedge clk) disable iff (!por_n)
    wdg_pulse |=> (sys_rst && pin_pull_low && !fetch_strobe));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    !cause_clr |=> ((cause & $past(cause)) == $past(cause)));

  p_one_new_bit_r10: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> $onehot0(cause & ~$past(cause)));

  p_clear_r11: assert property (@(posedge clk) disable iff (!por_n)
    cause_clr |=> ($countones(cause) <= 1));
endmodule

bind rst_seq_ctrl rsq_chk #(
  .AW(AW), .DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .wdg_pulse    (wdg_pulse),
  .dly_long     (dly_long),
  .cause_clr    (cause_clr),
  .sys_rst      (sys_rst),
  .pin_pull_low (pin_pull_low),
  .fetch_strobe (fetch_strobe),
  .fetch_addr   (fetch_addr),
  .cause        (cause),
  .phase        (phase_q)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
  localparam int CLK_P = 10;
  localparam int DS = 256;
  localparam int DL = 4096;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pin_sync_n = 1'b1;
  logic lvd_flag = 1'b0;
  logic wdg_pulse = 1'b0;
  logic dly_long = 1'b0;
  logic cause_clr = 1'b0;
  logic sys_rst, pin_pull_low, fetch_strobe;
  logic [15:0] fetch_addr;
  logic [2:0] cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_seq_ctrl u0 (
    .clk(clk), .por_n(por_n), .pin_sync_n(pin_sync_n), .lvd_flag(lvd_flag),
    .wdg_pulse(wdg_pulse), .dly_long(dly_long), .cause_clr(cause_clr),
    .sys_rst(sys_rst), .pin_pull_low(pin_pull_low), .fetch_strobe(fetch_strobe),
    .fetch_addr(fetch_addr), .cause(cause)
  );

  task automatic chk_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 active, 2 wait, 3/4 fetch; src 0 pin, 1 lvd, 2 wdg.
  int m_ph, m_src, m_cnt, m_run, m_cause;
  bit m_lvdp;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ph = 2; m_src = 0; m_cnt = 0; m_run = 0; m_cause = 0; m_lvdp = 0;
    end else begin
      bit msk, ereq, lreq, any, flow, fin;
      int best;
      msk  = (m_ph == 2) || (m_ph == 1 && m_src != 0);
      flow = (m_run == 3);
      ereq = !msk && !pin_sync_n && m_run == 2;
      lreq = lvd_flag && !m_lvdp;
      any  = ereq || lreq || wdg_pulse;
      best = wdg_pulse ? 2 : (lreq ? 1 : 0);
      m_run  = (msk || pin_sync_n) ? 0 : ((m_run < 3) ? m_run + 1 : 3);
      m_lvdp = lvd_flag;
      if (any || cause_clr) m_cause = (cause_clr ? 0 : m_cause) | (any ? (1 << best) : 0);
      if (any) begin
        m_ph = 1; m_src = best; m_cnt = 0;
      end else begin
        case (m_ph)
          1: begin
            if (m_src == 0)      fin = (m_cnt >= 3) && !flow;
            else if (m_src == 1) fin = !lvd_flag;
            else                 fin = (m_cnt == 29);
            if (fin) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
          end
          2: if (m_cnt == (dly_long ? DL : DS) - 1) begin m_ph = 3; m_cnt = 0; end
             else m_cnt++;
          3: m_ph = 4;
          4: m_ph = 0;
          default: m_ph = 0;
        endcase
      end
    end
  end

  // Every-clock comparison against the reference.
  always @(posedge clk) begin
    #2;
    if (!done) begin
      int ea;
      ea = (m_ph == 3) ? 16'hFFFE : ((m_ph == 4) ? 16'hFFFF : 0);
      chk_eq("R8 sys_rst", int'(sys_rst), int'(m_ph != 0));
      chk_eq("R6 pin_pull_low", int'(pin_pull_low), int'((m_ph == 2) || (m_ph == 1 && m_src != 0)));
      chk_eq("R7 fetch_strobe", int'(fetch_strobe), int'(m_ph == 3 || m_ph == 4));
      chk_eq("R7 fetch_addr", int'(fetch_addr), ea);
      chk_eq("R10 cause", int'(cause), m_cause);
    end
  end

  int n_rst, n_pull;
  int fq[$];

  task automatic clr_counts();
    n_rst = 0; n_pull = 0; fq.delete();
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
    n_rst  += int'(sys_rst);
    n_pull += int'(pin_pull_low);
    if (fetch_strobe) fq.push_back(int'(fetch_addr));
  endtask

  task automatic run_idle();
    int guard = 0;
    while (sys_rst && guard < 6000) begin tick(); guard++; end
  endtask

  task automatic chk_fetch(string tag);
    chk_eq({tag, " fetch count"}, fq.size(), 2);
    if (fq.size() == 2) begin
      chk_eq({tag, " first addr"}, fq[0], 16'hFFFE);
      chk_eq({tag, " second addr"}, fq[1], 16'hFFFF);
    end
  endtask

  task automatic wdg_once();
    wdg_pulse = 1'b1; tick(); wdg_pulse = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk_eq("R1 sys_rst in power-on", int'(sys_rst), 1);
    chk_eq("R1 pin_pull_low in power-on", int'(pin_pull_low), 1);
    chk_eq("R1 cause in power-on", int'(cause), 0);
    por_n = 1'b1;
    clr_counts();
    run_idle();
    chk_eq("R1 reset cycles after release", n_rst, DS - 1 + 2);
    chk_fetch("R1");
    chk_eq("R8 released", int'(sys_rst), 0);

    // R2: two-sample glitch ignored
    clr_counts();
    pin_sync_n = 1'b0; repeat (2) tick(); pin_sync_n = 1'b1;
    repeat (6) tick();
    chk_eq("R2 glitch no reset", n_rst, 0);

    // R3: short pin pulse gives the minimum active length
    clr_counts();
    pin_sync_n = 1'b0; repeat (3) tick(); pin_sync_n = 1'b1;
    run_idle();
    chk_eq("R3 minimum active", n_rst, 4 + DS + 2);
    chk_eq("R3 no pull in pin active", n_pull, DS);
    chk_eq("R10 pin cause", int'(cause), 1);

    // R3: long hold stretches active phase
    clr_counts();
    pin_sync_n = 1'b0; repeat (20) tick(); pin_sync_n = 1'b1;
    run_idle();
    chk_eq("R3 held active", n_rst, 19 + DS + 2);

    // R4: voltage flag held for 10 cycles
    clr_counts();
    lvd_flag = 1'b1; repeat (10) tick(); lvd_flag = 1'b0;
    run_idle();
    chk_eq("R4 lvd pull", n_pull, 10 + DS);
    chk_eq("R4 lvd reset", n_rst, 10 + DS + 2);
    chk_eq("R10 sticky pin+lvd", int'(cause), 3);

    // R11 + R5: clear together with watchdog
    clr_counts();
    cause_clr = 1'b1; wdg_pulse = 1'b1; tick(); cause_clr = 1'b0; wdg_pulse = 1'b0;
    chk_eq("R11 clear with request", int'(cause), 4);
    run_idle();
    chk_eq("R5 wdg pull", n_pull, 30 + DS);
    chk_eq("R5 wdg reset", n_rst, 30 + DS + 2);
    chk_fetch("R7");

    // R11: plain clear
    cause_clr = 1'b1; tick(); cause_clr = 1'b0;
    chk_eq("R11 plain clear", int'(cause), 0);

    // R10: watchdog outranks voltage flag
    lvd_flag = 1'b1; wdg_pulse = 1'b1; tick(); wdg_pulse = 1'b0;
    repeat (5) tick(); lvd_flag = 1'b0;
    run_idle();
    chk_eq("R10 priority wdg over lvd", int'(cause), 4);

    // R9: restart inside the wait phase
    wdg_once(); repeat (100) tick();
    clr_counts();
    wdg_once();
    run_idle();
    chk_eq("R9 restart in wait pull", n_pull, 30 + DS);
    chk_fetch("R9");

    // R9: restart inside the fetch phase
    wdg_once();
    begin
      int g = 0;
      while (!fetch_strobe && g < 6000) begin tick(); g++; end
    end
    wdg_once();
    chk_eq("R9 restart in fetch sys_rst", int'(sys_rst), 1);
    chk_eq("R9 restart in fetch strobe", int'(fetch_strobe), 0);
    chk_eq("R9 restart in fetch pull", int'(pin_pull_low), 1);
    run_idle();

    // R3: pin still held low when the sequence ends is re-qualified
    pin_sync_n = 1'b0; repeat (3) tick();
    wdg_once();
    run_idle();
    repeat (3) tick();
    chk_eq("R3 held pin re-qualified", int'(sys_rst), 1);
    pin_sync_n = 1'b1;
    run_idle();

    // R6: long wait
    dly_long = 1'b1;
    clr_counts();
    wdg_once();
    run_idle();
    chk_eq("R6 long wait pull", n_pull, 30 + DL);
    chk_eq("R6 long wait reset", n_rst, 30 + DL + 2);
    chk_fetch("R6");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule